// File: doc/BRIEF.md
# Serial Result Port for a Pin-Configured Converter

This block is the device-side digital port of a read-only sigma-delta converter. Nothing in it is programmable. A parallel 24-bit result arrives from the conversion core and is captured once per conversion period. The block then shifts the result out, most significant bit first, on a single output. That output also serves as the data-ready flag: it is high while no readable result exists and low once a fresh result is waiting.

A pin selects the clock direction:
- **Master mode** (`mode` = 0): the block generates the serial clock at one cycle per crystal period and sends all 24 bits as soon as a result is ready.
- **Slave mode** (`mode` = 1): the serial clock comes from outside. The host may send the 24 pulses in one burst or in several groups, with the clock held high between groups.

The block also handles the conversion timing:
- **Chip select**: while the active-low select is high, both outputs are released, any conversion is aborted and any held result is dropped.
- **Conversion timebase**: counted in crystal cycles. After select falls, the first result appears only after two full conversion periods of settling.
- **Update guard**: an unread result is withdrawn a few crystal cycles before the next capture, so a read never overlaps an update.

The block clock `clk` runs at `DIV` times the crystal rate, and `DIV` must be even. The conversion period is `CONV_XTAL` crystal cycles, 1656 by default. The guard window is `LEAD_XTAL` crystal cycles, 4 by default. Tri-state pins are modelled as a value plus an output enable.

Top module: `adc_serial_port`

## Requirements
- R1: With `mode`=0 and `cs_n` low, `sclk_oe` is 1 and the block drives `sclk_out`. With `mode`=1, `sclk_oe` is 0 and `sclk_out` stays high.
- R2: Each result is sent as 24 bits, bit 23 first, down to bit 0. The read word equals `result_in` as sampled at the capture.
- R3: `dout_rdy` goes low in the first cycle after a capture. In master mode it is low for at least half a serial clock period before the first falling edge.
- R4: A bit changes only after a falling serial clock edge and holds through the following rising edge. The serial clock idles high.
- R5: In master mode exactly 24 serial clock cycles are produced per result, each lasting one crystal period (`DIV` clk cycles). Afterwards `sclk_out` and `dout_rdy` are both high.
- R6: In slave mode the 24 bits can be read with one continuous burst of pulses or in groups of 8 with idle-high gaps, and both give the same word.
- R7: Once the 24th bit has been clocked, `dout_rdy` returns high. It stays high, ignoring any further serial clock pulses, until the next capture.
- R8: `dout_rdy` is forced high during the `LEAD_XTAL` crystal cycles before every capture. A slave read still in progress then is cut off, and the next read starts at bit 23 of the new result.
- R9: While `cs_n` is high, `dout_oe` and `sclk_oe` are 0, and the conversion and any held result are discarded. After `cs_n` falls, the first capture happens after 2×`CONV_XTAL` crystal cycles, and `dout_rdy` stays high until then.
- R10: After the first capture, further captures follow every `CONV_XTAL` crystal cycles while `cs_n` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, `DIV` ticks per crystal cycle |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; high means standby and abort |
| mode | input | 1 | 0 = master (block drives clock), 1 = slave |
| result_in | input | 24 | Parallel result from the conversion core |
| sclk_in | input | 1 | Serial clock from the host in slave mode |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Output enable for `sclk_out` |
| dout_rdy | output | 1 | Combined data output and active-low ready flag |
| dout_oe | output | 1 | Output enable for `dout_rdy` |

## Verification
The assertions assume that `mode` is static while `cs_n` is low, and that `sclk_in` idles high and changes slowly compared with `clk`, so the three-stage synchronizer sees every level. The stimulus respects both assumptions:
- `mode` is changed only while the port is deselected.
- Each slave clock phase is held for six `clk` cycles.
- Slave reads begin right after the ready edge, so they end well before the update guard unless the cut-off case is being exercised on purpose.

// File: rtl/adcport_pkg.sv
package adcport_pkg;

    localparam int WORD_BITS = 24;
    localparam int BIT_W     = $clog2(WORD_BITS + 1);

    typedef logic [WORD_BITS-1:0] word_t;

    typedef enum logic {
        MODE_MASTER = 1'b0,
        MODE_SLAVE  = 1'b1
    } port_mode_e;

    // One-cycle serial clock edge events fed to the shifter
    typedef struct packed {
        logic fall;
        logic rise;
    } edge_t;

endpackage

// File: rtl/adcport_timebase.sv
module adcport_timebase #(
    parameter int CONV_XTAL = 1656,
    parameter int DIV       = 2,
    parameter int LEAD_XTAL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    output logic update,
    output logic blank
);
    localparam int PERIOD = CONV_XTAL * DIV;
    localparam int FIRST  = 2 * PERIOD;
    localparam int LEAD   = LEAD_XTAL * DIV;
    localparam int CW     = $clog2(FIRST + 1);

    localparam logic [CW-1:0] LAST_FIRST = CW'(FIRST - 1);
    localparam logic [CW-1:0] LAST_NEXT  = CW'(PERIOD - 1);
    localparam logic [CW-1:0] BL_FIRST   = CW'(FIRST - 1 - LEAD);
    localparam logic [CW-1:0] BL_NEXT    = CW'(PERIOD - 1 - LEAD);

    logic [CW-1:0] cnt;
    logic          settling;

    assign update = !cs_n && (cnt == (settling ? LAST_FIRST : LAST_NEXT));
    assign blank  = !cs_n && (cnt >= (settling ? BL_FIRST : BL_NEXT));

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            cnt      <= '0;
            settling <= 1'b1;
        end else if (update) begin
            cnt      <= '0;
            settling <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10
    period_restart_chk: assert property (@(posedge clk) disable iff (rst)
        update |=> (cnt == '0));

    // R8
    guard_before_update_chk: assert property (@(posedge clk) disable iff (rst)
        update |-> $past(blank));

endmodule

// File: rtl/adcport_mclk.sv
module adcport_mclk
    import adcport_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  more,
    output logic  sclk,
    output edge_t ev
);
    localparam int HALF = (DIV / 2 < 1) ? 1 : DIV / 2;
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [HW-1:0] hcnt;
    logic          tick;

    assign tick = run && (hcnt == HW'(HALF - 1));

    always_comb begin
        ev      = '0;
        ev.fall = tick && sclk && more;
        ev.rise = tick && !sclk;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt <= '0;
            sclk <= 1'b1;
        end else begin
            hcnt <= tick ? '0 : hcnt + 1'b1;
            if (ev.fall)
                sclk <= 1'b0;
            else if (ev.rise)
                sclk <= 1'b1;
        end
    end

    // R5
    fall_needs_bits_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> $past(more));

    // R4
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> sclk);

endmodule

// File: rtl/adcport_shifter.sv
module adcport_shifter
    import adcport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n,
    input  logic  update,
    input  logic  blank,
    input  word_t word_in,
    input  edge_t ev,
    output logic  dout,
    output logic  more,
    output logic  have
);
    logic [BIT_W-1:0] nbit;
    word_t            shreg;

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            have  <= 1'b0;
            nbit  <= '0;
            shreg <= '0;
        end else if (update) begin
            have  <= 1'b1;
            nbit  <= '0;
            shreg <= word_in;
        end else if (blank) begin
            have <= 1'b0;
            nbit <= '0;
        end else if (have) begin
            if (ev.fall && more) begin
                if (nbit != '0)
                    shreg <= shreg << 1;
                nbit <= nbit + 1'b1;
            end else if (ev.rise && !more) begin
                have <= 1'b0;
            end
        end
    end

    assign more = have && (nbit < BIT_W'(WORD_BITS));
    assign dout = !have ? 1'b1 : ((nbit == '0) ? 1'b0 : shreg[WORD_BITS-1]);

    // R9
    drop_on_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !have);

    // R8
    guard_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (blank && !update) |=> !have);

    // R2
    bit_bound_chk: assert property (@(posedge clk) disable iff (rst)
        nbit <= BIT_W'(WORD_BITS));

    // R4
    hold_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.rise && !ev.fall && !update && !blank && !cs_n) |=> $stable(shreg));

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adcport_pkg::*;
#(
    parameter int CONV_XTAL = 1656,
    parameter int DIV       = 2,
    parameter int LEAD_XTAL = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        mode,
    input  logic [23:0] result_in,
    input  logic        sclk_in,
    output logic        sclk_out,
    output logic        sclk_oe,
    output logic        dout_rdy,
    output logic        dout_oe
);
    logic       update, blank, have, more, run, is_master;
    logic [2:0] s_q;
    edge_t      s_ev, m_ev, ev;

    assign is_master = (port_mode_e'(mode) == MODE_MASTER);

    // Slave clock synchronizer, idles high
    always_ff @(posedge clk) begin
        if (rst)
            s_q <= 3'b111;
        else
            s_q <= {s_q[1:0], sclk_in};
    end

    always_comb begin
        s_ev      = '0;
        s_ev.fall = !is_master && s_q[2] && !s_q[1];
        s_ev.rise = !is_master && !s_q[2] && s_q[1];
    end

    assign ev  = is_master ? m_ev : s_ev;
    assign run = !cs_n && is_master && have && !blank;

    adcport_timebase #(
        .CONV_XTAL (CONV_XTAL),
        .DIV       (DIV),
        .LEAD_XTAL (LEAD_XTAL)
    ) u_tb (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .update (update),
        .blank  (blank)
    );

    adcport_mclk #(
        .DIV (DIV)
    ) u_mclk (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .more (more),
        .sclk (sclk_out),
        .ev   (m_ev)
    );

    adcport_shifter u_sh (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .update  (update),
        .blank   (blank),
        .word_in (result_in),
        .ev      (ev),
        .dout    (dout_rdy),
        .more    (more),
        .have    (have)
    );

    assign sclk_oe = !cs_n && is_master;
    assign dout_oe = !cs_n;

    // R1
    slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !is_master |=> sclk_out);

endmodule

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
    localparam int CONV = 300;
    localparam int DIV  = 2;
    localparam int P    = CONV * DIV;
    localparam int LEAD = 4 * DIV;

    logic        clk = 1'b0, rst = 1'b1, cs_n = 1'b1, mode = 1'b1, sclk_in = 1'b1;
    logic [23:0] result_in = '0;
    logic        sclk_out, sclk_oe, dout_rdy, dout_oe;

    adc_serial_port #(.CONV_XTAL(CONV), .DIV(DIV), .LEAD_XTAL(4)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .mode(mode), .result_in(result_in),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .dout_rdy(dout_rdy), .dout_oe(dout_oe));

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0, t_ready = 0, words = 0;
    bit mon_en = 0;
    logic [23:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic wait_ready();
        int n = 0;
        while (dout_rdy !== 1'b0 && n < 4 * P) begin @(negedge clk); n++; end
        t_ready = cyc;
    endtask

    task automatic slave_read(input int n, inout logic [23:0] w);
        for (int i = 0; i < n; i++) begin
            sclk_in = 1'b0;
            repeat (6) @(negedge clk);
            w = {w[22:0], dout_rdy};
            sclk_in = 1'b1;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic settle_check();
        repeat (2 * P - 1) @(posedge clk);
        @(negedge clk);
        chk(dout_rdy === 1'b1, "R9 settle", dout_rdy, 1);
        @(posedge clk); @(negedge clk);
        chk(dout_rdy === 1'b0, "R3 ready", dout_rdy, 0);
        t_ready = cyc;
    endtask

    // Master-mode monitor: pops expected words from the scoreboard queue
    int nb = 0, nf = 0;
    bit prev_s = 1, prev_d = 1, idle_chk = 0;
    logic [23:0] mw = '0;
    always @(negedge clk) begin
        #2;
        if (mon_en) begin
            if (!dout_oe) begin
                nb = 0; nf = 0; prev_s = 1; prev_d = 1; idle_chk = 0;
            end else begin
                if (idle_chk) begin
                    chk(sclk_out === 1'b1 && dout_rdy === 1'b1, "R5 idle", {sclk_out, dout_rdy}, 2'b11);
                    idle_chk = 0;
                end
                if (prev_s && !sclk_out) begin
                    if (nf == 0) chk(prev_d == 1'b0, "R3 lead", prev_d, 0);
                    nf++;
                end
                if (!sclk_out) begin
                    mw = {mw[22:0], dout_rdy};
                    nb++;
                    if (nb == 24) begin
                        if (exp_q.size() > 0) chk(mw === exp_q[0], "R2 master word", mw, exp_q[0]);
                        else chk(0, "R2 unexpected word", mw, 0);
                        if (exp_q.size() > 0) void'(exp_q.pop_front());
                        chk(nf == 24, "R5 clock count", nf, 24);
                        nb = 0; nf = 0; words++; idle_chk = 1;
                    end
                end
                prev_s = sclk_out; prev_d = dout_rdy;
            end
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [23:0] w, junk;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dout_oe === 1'b0, "R9 reset oe", dout_oe, 0);
        chk(sclk_oe === 1'b0, "R9 reset sclk_oe", sclk_oe, 0);
        chk(dout_rdy === 1'b1, "R7 reset dout", dout_rdy, 1);
        chk(sclk_out === 1'b1, "R4 reset sclk", sclk_out, 1);

        // Slave mode, continuous burst
        result_in = 24'hA53C96; exp_q.push_back(24'hA53C96);
        cs_n = 1'b0; #1;
        chk(sclk_oe === 1'b0, "R1 slave no drive", sclk_oe, 0);
        chk(dout_oe === 1'b1, "R9 select oe", dout_oe, 1);
        settle_check();
        result_in = 24'h5F0E71; exp_q.push_back(24'h5F0E71);
        w = '0; slave_read(24, w);
        chk(w === exp_q[0], "R6 continuous R2", w, exp_q[0]); void'(exp_q.pop_front());
        chk(dout_rdy === 1'b1, "R7 high after read", dout_rdy, 1);
        junk = '0; slave_read(2, junk);
        chk(dout_rdy === 1'b1 && junk[1:0] === 2'b11, "R7 extra pulses ignored", {dout_rdy, junk[1:0]}, 3'b111);
        wait_until(t_ready + P - 1);
        chk(dout_rdy === 1'b1, "R10 before update", dout_rdy, 1);
        @(negedge clk);
        chk(dout_rdy === 1'b0, "R10 period", dout_rdy, 0);
        t_ready = cyc;

        // Slave mode, three batches of 8
        result_in = 24'h00FF81; exp_q.push_back(24'h00FF81);
        w = '0;
        for (int g = 0; g < 3; g++) begin slave_read(8, w); repeat (20) @(negedge clk); end
        chk(w === exp_q[0], "R6 batches", w, exp_q[0]); void'(exp_q.pop_front());

        // Unread result: withdrawn before the update
        wait_ready();
        result_in = 24'hC3A1F0; exp_q.push_back(24'hC3A1F0);
        void'(exp_q.pop_front()); // 00FF81 stays unread
        wait_until(t_ready + P - LEAD - 1);
        chk(dout_rdy === 1'b0, "R8 still ready", dout_rdy, 0);
        @(negedge clk);
        chk(dout_rdy === 1'b1, "R8 guard high", dout_rdy, 1);
        wait_until(t_ready + P - 1);
        chk(dout_rdy === 1'b1, "R8 guard length", dout_rdy, 1);
        @(negedge clk);
        chk(dout_rdy === 1'b0, "R8 new result", dout_rdy, 0);
        t_ready = cyc;

        // Partial read cut off by the guard
        result_in = 24'h1B2D3E; exp_q.push_back(24'h1B2D3E);
        w = '0; slave_read(8, w);
        chk(w[7:0] === exp_q[0][23:16], "R2 first byte", w[7:0], exp_q[0][23:16]);
        void'(exp_q.pop_front());
        wait_until(t_ready + P - LEAD);
        chk(dout_rdy === 1'b1, "R8 cut off", dout_rdy, 1);
        wait_until(t_ready + P);
        chk(dout_rdy === 1'b0, "R8 restart ready", dout_rdy, 0);
        w = '0; slave_read(24, w);
        chk(w === exp_q[0], "R8 restart from msb", w, exp_q[0]); void'(exp_q.pop_front());

        // Master mode
        cs_n = 1'b1; #1;
        chk(dout_oe === 1'b0 && sclk_oe === 1'b0, "R9 deselect", {dout_oe, sclk_oe}, 0);
        mode = 1'b0;
        result_in = 24'h96E14B; exp_q.push_back(24'h96E14B);
        @(negedge clk);
        mon_en = 1;
        cs_n = 1'b0; #1;
        chk(sclk_oe === 1'b1, "R1 master drives", sclk_oe, 1);
        settle_check();
        result_in = 24'h7A0C35; exp_q.push_back(24'h7A0C35);
        wait_until(t_ready + P);
        chk(dout_rdy === 1'b0, "R10 master period", dout_rdy, 0);
        t_ready = cyc;
        wait_until(t_ready + P);
        chk(dout_rdy === 1'b0, "R10 master third", dout_rdy, 0);
        repeat (10) @(negedge clk);
        cs_n = 1'b1; #1;
        chk(dout_oe === 1'b0 && sclk_oe === 1'b0, "R9 abort oe", {dout_oe, sclk_oe}, 0);
        chk(words == 2, "R5 words before abort", words, 2);

        // Reselect: discarded result, fresh settle
        result_in = 24'hE4D2B8; exp_q.push_back(24'hE4D2B8);
        @(negedge clk);
        cs_n = 1'b0;
        settle_check();
        repeat (100) @(negedge clk);
        chk(words == 3, "R9 word after reselect", words, 3);
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule